// File: doc/BRIEF.md
# Bus Fault Frame Restore Checker

When a processor returns from a bus-fault handler, the frame it stacked at fault time must be validated before execution resumes. This block takes a stack pointer and a layout flag, then fetches two words of that frame over a word-wide read port. The first is the saved status word. The second is the internal word that packs a microcode revision with a block-move transfer count. The block then decides whether the frame may be restored.

The frame type sits in the two top bits of the status word. The stacked revision must match a revision constant built into the block. If any check fails, the block ends the restore with a format error. If the frame is accepted and the move-continuation bit is set, the block hands the stacked count to the block-move transfer counter as a single-cycle load.

The caller says which layout applies. The compact four-word exception frame sits lower on the stack than the full-size frames, so the word offsets differ between the two layouts.

Top module: `bus_fault_frame_check`

## Requirements
- R1: After reset, and until a start is accepted, memReq, done, formatErr and cntLoad are all low.
- R2: With shortFrame low, the first read goes to stackPtr+0x16 (status word) and the second read goes to stackPtr+0x14 (transfer word).
- R3: With shortFrame high, the first read goes to stackPtr+0x12 (status word) and the second read goes to stackPtr+0x10 (transfer word).
- R4: Each read holds memReq high with a stable memAddr until memAck is seen. Only one read is outstanding at a time. Exactly two reads are made per start, and memReq is low while done is high.
- R5: The revision in bits 15:8 of the transfer word is compared with LOCAL_REV. On a mismatch, formatErr is raised and cntLoad stays low.
- R6: The frame type is status bits 15:14, where bit 15 is the type bit and bit 14 is the move-continuation bit. In the full layout, types 00, 01 and 10 pass and type 11 gives formatErr with no load.
- R7: In the short layout only type 10 passes. Every other type gives formatErr with no load.
- R8: When a frame passes and status bit 14 is 1, cntLoad pulses together with done and cntValue equals transfer-word bits 7:0. Otherwise cntLoad is low and cntValue is 0.
- R9: done is a one-cycle pulse in the cycle after the second memAck is sampled. formatErr is valid in that same cycle and is low in every other cycle.
- R10: A start that arrives while a check is in progress is ignored. It changes no address and produces no extra done.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a frame check (sampled only when idle) |
| stackPtr | input | ADDR_W | Stack pointer that frame offsets are added to |
| shortFrame | input | 1 | 1 selects the compact four-word layout |
| memReq | output | 1 | Read request, held until memAck |
| memAddr | output | ADDR_W | Read byte address |
| memAck | input | 1 | Read completes; memRdata valid this cycle |
| memRdata | input | REV_W+CNT_W | Read data word |
| done | output | 1 | One-cycle completion pulse |
| formatErr | output | 1 | Frame rejected; valid with done |
| cntLoad | output | 1 | Load strobe for the block-move transfer counter |
| cntValue | output | CNT_W | Count to load; zero when cntLoad is low |

## Verification
The bench keeps the default 24-bit address, 8-bit revision and 8-bit count widths, and builds the block with LOCAL_REV set to 0x5C. With those values it can sweep every combination of layout flag, all four type encodings and revision match or mismatch, using a different stack pointer, count and ack latency of 0 to 2 cycles for each frame. Words at the unused layout's offsets are filled with a poison value, so a wrong offset shows up as a wrong decision, not only as a wrong address. One extra run fires a second start while the check is busy.

// File: rtl/bfc_pkg.sv
package bfc_pkg;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_STAT,
    ST_XFER,
    ST_DONE
  } bfcState_t;

  typedef struct packed {
    logic capture;   // take stackPtr and layout flag
    logic takeStat;  // latch status word
    logic takeXfer;  // latch transfer word
    logic selXfer;   // address the transfer word
  } bfcStrobe_t;

  localparam logic [1:0] TYPE_NORMAL  = 2'b00;
  localparam logic [1:0] TYPE_BLKMOVE = 2'b01;
  localparam logic [1:0] TYPE_EXCEPT  = 2'b10;
  localparam logic [1:0] TYPE_RSVD    = 2'b11;

endpackage

// File: rtl/bfc_control.sv
module bfc_control
  import bfc_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       start,
  input  logic       memAck,
  output bfcStrobe_t strobe,
  output logic       memReq,
  output logic       done
);

  bfcState_t state, stateNext;

  always_ff @(posedge clk) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= stateNext;
  end

  always_comb begin
    stateNext = state;
    unique case (state)
      ST_IDLE: if (start)  stateNext = ST_STAT;
      ST_STAT: if (memAck) stateNext = ST_XFER;
      ST_XFER: if (memAck) stateNext = ST_DONE;
      ST_DONE:             stateNext = ST_IDLE;
      default:             stateNext = ST_IDLE;
    endcase
  end

  always_comb begin
    strobe.capture  = (state == ST_IDLE) && start;
    strobe.takeStat = (state == ST_STAT) && memAck;
    strobe.takeXfer = (state == ST_XFER) && memAck;
    strobe.selXfer  = (state == ST_XFER);
    memReq          = (state == ST_STAT) || (state == ST_XFER);
    done            = (state == ST_DONE);
  end

endmodule

// File: rtl/bfc_datapath.sv
module bfc_datapath
  import bfc_pkg::*;
#(
  parameter int unsigned     ADDR_W         = 24,
  parameter int unsigned     REV_W          = 8,
  parameter int unsigned     CNT_W          = 8,
  parameter logic [REV_W-1:0] LOCAL_REV     = 8'h01,
  parameter int unsigned     FULL_STAT_OFF  = 'h16,
  parameter int unsigned     FULL_XFER_OFF  = 'h14,
  parameter int unsigned     SHORT_STAT_OFF = 'h12,
  parameter int unsigned     SHORT_XFER_OFF = 'h10
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  bfcStrobe_t              strobe,
  input  logic [ADDR_W-1:0]       stackPtr,
  input  logic                    shortFrame,
  input  logic [REV_W+CNT_W-1:0]  memRdata,
  output logic [ADDR_W-1:0]       memAddr,
  output logic                    frameOk,
  output logic                    mvSet,
  output logic [CNT_W-1:0]        loadVal
);

  localparam int unsigned WORD_W = REV_W + CNT_W;
  localparam logic [ADDR_W-1:0] FULL_STAT_A  = ADDR_W'(FULL_STAT_OFF);
  localparam logic [ADDR_W-1:0] FULL_XFER_A  = ADDR_W'(FULL_XFER_OFF);
  localparam logic [ADDR_W-1:0] SHORT_STAT_A = ADDR_W'(SHORT_STAT_OFF);
  localparam logic [ADDR_W-1:0] SHORT_XFER_A = ADDR_W'(SHORT_XFER_OFF);

  logic [ADDR_W-1:0] ptrQ;
  logic              shortQ;
  logic [WORD_W-1:0] statQ;
  logic [WORD_W-1:0] xferQ;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      ptrQ   <= '0;
      shortQ <= 1'b0;
      statQ  <= '0;
      xferQ  <= '0;
    end else begin
      if (strobe.capture) begin
        ptrQ   <= stackPtr;
        shortQ <= shortFrame;
      end
      if (strobe.takeStat) statQ <= memRdata;
      if (strobe.takeXfer) xferQ <= memRdata;
    end
  end

  logic [ADDR_W-1:0] offset;
  always_comb begin
    unique case ({shortQ, strobe.selXfer})
      2'b00:   offset = FULL_STAT_A;
      2'b01:   offset = FULL_XFER_A;
      2'b10:   offset = SHORT_STAT_A;
      default: offset = SHORT_XFER_A;
    endcase
  end
  assign memAddr = ptrQ + offset;

  logic [1:0]       frameType;
  logic [REV_W-1:0] stackedRev;
  logic             typeOk;
  logic             revOk;

  assign frameType  = statQ[WORD_W-1 -: 2];
  assign stackedRev = xferQ[WORD_W-1 -: REV_W];
  assign revOk      = (stackedRev == LOCAL_REV);

  always_comb begin
    if (shortQ) typeOk = (frameType == TYPE_EXCEPT);
    else        typeOk = (frameType != TYPE_RSVD);
  end

  assign frameOk = revOk && typeOk;
  assign mvSet   = frameType[0];
  assign loadVal = xferQ[CNT_W-1:0];

endmodule

// File: rtl/bus_fault_frame_check.sv
module bus_fault_frame_check
  import bfc_pkg::*;
#(
  parameter int unsigned      ADDR_W         = 24,
  parameter int unsigned      REV_W          = 8,
  parameter int unsigned      CNT_W          = 8,
  parameter logic [REV_W-1:0] LOCAL_REV      = 8'h01,
  parameter int unsigned      FULL_STAT_OFF  = 'h16,
  parameter int unsigned      FULL_XFER_OFF  = 'h14,
  parameter int unsigned      SHORT_STAT_OFF = 'h12,
  parameter int unsigned      SHORT_XFER_OFF = 'h10
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  logic                   start,
  input  logic [ADDR_W-1:0]      stackPtr,
  input  logic                   shortFrame,
  output logic                   memReq,
  output logic [ADDR_W-1:0]      memAddr,
  input  logic                   memAck,
  input  logic [REV_W+CNT_W-1:0] memRdata,
  output logic                   done,
  output logic                   formatErr,
  output logic                   cntLoad,
  output logic [CNT_W-1:0]       cntValue
);

  bfcStrobe_t       strobe;
  logic             frameOk;
  logic             mvSet;
  logic [CNT_W-1:0] loadVal;

  bfc_control ctrl_i (
    .clk    (clk),
    .rstN   (rstN),
    .start  (start),
    .memAck (memAck),
    .strobe (strobe),
    .memReq (memReq),
    .done   (done)
  );

  bfc_datapath #(
    .ADDR_W         (ADDR_W),
    .REV_W          (REV_W),
    .CNT_W          (CNT_W),
    .LOCAL_REV      (LOCAL_REV),
    .FULL_STAT_OFF  (FULL_STAT_OFF),
    .FULL_XFER_OFF  (FULL_XFER_OFF),
    .SHORT_STAT_OFF (SHORT_STAT_OFF),
    .SHORT_XFER_OFF (SHORT_XFER_OFF)
  ) dp_i (
    .clk        (clk),
    .rstN       (rstN),
    .strobe     (strobe),
    .stackPtr   (stackPtr),
    .shortFrame (shortFrame),
    .memRdata   (memRdata),
    .memAddr    (memAddr),
    .frameOk    (frameOk),
    .mvSet      (mvSet),
    .loadVal    (loadVal)
  );

  assign formatErr = done && !frameOk;
  assign cntLoad   = done && frameOk && mvSet;
  assign cntValue  = cntLoad ? loadVal : '0;

endmodule

// File: rtl/bfc_checker.sv
module bfc_checker #(
  parameter int unsigned ADDR_W = 24,
  parameter int unsigned CNT_W  = 8
) (
  input logic              clk,
  input logic              rstN,
  input logic              memReq,
  input logic              memAck,
  input logic [ADDR_W-1:0] memAddr,
  input logic              done,
  input logic              formatErr,
  input logic              cntLoad,
  input logic [CNT_W-1:0]  cntValue
);

  assert_req_hold_R4: assert property (@(posedge clk) disable iff (!rstN)
    (memReq && !memAck) |=> (memReq && $stable(memAddr)));

  assert_no_req_at_done_R4: assert property (@(posedge clk) disable iff (!rstN)
    done |-> !memReq);

  assert_done_pulse_R9: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);

  assert_err_only_done_R9: assert property (@(posedge clk) disable iff (!rstN)
    formatErr |-> done);

  assert_load_accepted_R8: assert property (@(posedge clk) disable iff (!rstN)
    cntLoad |-> (done && !formatErr));

  assert_value_idle_R8: assert property (@(posedge clk) disable iff (!rstN)
    !cntLoad |-> (cntValue == '0));

endmodule

bind bus_fault_frame_check bfc_checker #(
  .ADDR_W (ADDR_W),
  .CNT_W  (CNT_W)
) chk_i (
  .clk       (clk),
  .rstN      (rstN),
  .memReq    (memReq),
  .memAck    (memAck),
  .memAddr   (memAddr),
  .done      (done),
  .formatErr (formatErr),
  .cntLoad   (cntLoad),
  .cntValue  (cntValue)
);

// File: tb/bus_fault_frame_check_tb_top.sv
module bus_fault_frame_check_tb_top;

  localparam int unsigned ADDR_W = 24;
  localparam logic [7:0]  REV    = 8'h5C;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        start = 1'b0;
  logic [23:0] stackPtr = '0;
  logic        shortFrame = 1'b0;
  logic        memReq;
  logic [23:0] memAddr;
  logic        memAck;
  logic [15:0] memRdata;
  logic        done, formatErr, cntLoad;
  logic [7:0]  cntValue;

  int checks = 0;
  int errors = 0;

  always #4 clk = ~clk;

  bus_fault_frame_check #(.LOCAL_REV(REV)) dut_i (
    .clk(clk), .rstN(rstN), .start(start), .stackPtr(stackPtr),
    .shortFrame(shortFrame), .memReq(memReq), .memAddr(memAddr),
    .memAck(memAck), .memRdata(memRdata), .done(done),
    .formatErr(formatErr), .cntLoad(cntLoad), .cntValue(cntValue)
  );

  // word memory and read responder
  logic [15:0] mem [0:2047];
  logic [23:0] reqAddr [0:15];
  int          reqCount = 0;
  int          waitCnt = 0;
  int          ackLat = 0;
  int          doneCount = 0;

  always @(posedge clk) begin
    if (!rstN) begin
      memAck   <= 1'b0;
      memRdata <= '0;
      waitCnt  <= 0;
    end else if (memAck) begin
      memAck <= 1'b0;
    end else if (memReq) begin
      if (waitCnt >= ackLat) begin
        memAck   <= 1'b1;
        memRdata <= mem[memAddr[11:1]];
        reqAddr[reqCount % 16] <= memAddr;
        reqCount <= reqCount + 1;
        waitCnt  <= 0;
      end else begin
        waitCnt <= waitCnt + 1;
      end
    end
  end

  always @(posedge clk) if (done) doneCount <= doneCount + 1;

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
    end
  endtask

  task automatic runFrame(input logic [23:0] sp, input bit sh, input logic [1:0] ty,
                          input bit revMatch, input logic [7:0] cnt, input int lat,
                          input bit probeBusy);
    logic [15:0] statW, xferW;
    logic [23:0] expStat, expXfer;
    bit expOk, expLoad, prevAck, seen, doneErr, doneLoad;
    logic [7:0] doneVal;
    int base, doneBase, n;
    statW = {ty, 14'(sp[13:0] ^ 14'h1A5)};
    xferW = {revMatch ? REV : (REV ^ 8'h81), cnt};
    expStat = sp + (sh ? 24'h12 : 24'h16);
    expXfer = sp + (sh ? 24'h10 : 24'h14);
    // poison every slot of both layouts, then place the real words
    mem[(sp + 24'h10) >> 1] = 16'hFFFF;
    mem[(sp + 24'h12) >> 1] = 16'hFFFF;
    mem[(sp + 24'h14) >> 1] = 16'hFFFF;
    mem[(sp + 24'h16) >> 1] = 16'hFFFF;
    mem[expStat[11:1]] = statW;
    mem[expXfer[11:1]] = xferW;
    expOk   = revMatch && (sh ? (ty == 2'b10) : (ty != 2'b11));
    expLoad = expOk && ty[0];
    ackLat  = lat;
    base     = reqCount;
    doneBase = doneCount;

    @(negedge clk);
    start = 1'b1; stackPtr = sp; shortFrame = sh;
    @(negedge clk);
    start = 1'b0;
    if (probeBusy) begin
      // R10: second start while busy, different pointer and layout
      start = 1'b1; stackPtr = sp ^ 24'h000400; shortFrame = !sh;
      @(negedge clk);
      start = 1'b0;
    end

    prevAck = 1'b0; seen = 1'b0; n = 0;
    while (!seen && n < 100) begin
      if (done) seen = 1'b1;
      else begin
        prevAck = memAck;
        @(negedge clk);
        n++;
      end
    end
    chk(seen, "R9", "done seen", 32'(seen), 1);
    doneErr = formatErr; doneLoad = cntLoad; doneVal = cntValue;
    chk(prevAck, "R9", "done one cycle after second ack", 32'(prevAck), 1);
    chk(reqCount - base == 2, "R4", "read count", 32'(reqCount - base), 2);
    chk(reqAddr[base % 16] == expStat, sh ? "R3" : "R2", "status address",
        32'(reqAddr[base % 16]), 32'(expStat));
    chk(reqAddr[(base + 1) % 16] == expXfer, sh ? "R3" : "R2", "transfer address",
        32'(reqAddr[(base + 1) % 16]), 32'(expXfer));
    chk(doneErr == !expOk, revMatch ? (sh ? "R7" : "R6") : "R5", "formatErr",
        32'(doneErr), 32'(!expOk));
    chk(doneLoad == expLoad, "R8", "cntLoad", 32'(doneLoad), 32'(expLoad));
    chk(doneVal == (expLoad ? cnt : 8'h00), "R8", "cntValue",
        32'(doneVal), 32'(expLoad ? cnt : 8'h00));
    @(negedge clk);
    chk(!done && !formatErr && !cntLoad, "R9", "pulse ended",
        {29'b0, done, formatErr, cntLoad}, 0);
    repeat (3) @(negedge clk);
    chk(doneCount - doneBase == 1, probeBusy ? "R10" : "R9", "done count",
        32'(doneCount - doneBase), 1);
    chk(!memReq, probeBusy ? "R10" : "R4", "idle after done", 32'(memReq), 0);
  endtask

  initial begin
    for (int i = 0; i < 2048; i++) mem[i] = 16'hFFFF;
    repeat (3) @(negedge clk);
    chk(!memReq && !done && !formatErr && !cntLoad, "R1", "reset outputs",
        {28'b0, memReq, done, formatErr, cntLoad}, 0);
    rstN = 1'b1;
    repeat (2) @(negedge clk);
    chk(!memReq && !done && !formatErr && !cntLoad, "R1", "idle outputs",
        {28'b0, memReq, done, formatErr, cntLoad}, 0);

    for (int sh = 0; sh < 2; sh++)
      for (int ty = 0; ty < 4; ty++)
        for (int rv = 0; rv < 2; rv++) begin
          int idx;
          idx = sh * 8 + ty * 2 + rv;
          runFrame(24'h7A0040 + 24'(idx * 'h40), sh[0], ty[1:0], rv[0],
                   8'(idx * 29 + 3), idx % 3, 1'b0);
        end

    // R10: busy start during an accepted block-move frame
    runFrame(24'h3C0500, 1'b0, 2'b01, 1'b1, 8'hA7, 2, 1'b1);
    // R8: exception type on full layout, count must not load
    runFrame(24'h3C0580, 1'b0, 2'b10, 1'b1, 8'h11, 1, 1'b0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule